// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

This block is a synthesizable stand-in for a 16-bit-wide static RAM whose pins are normally driven asynchronously. Here every pin is sampled on a system clock. The block has two chip enables of opposite polarity, an active-low write strobe and an active-low output enable. Each byte of the word has its own active-low enable. Writes update only the enabled bytes of the addressed word. Reads return only the enabled bytes, and only after the read has been held steady for a configurable number of clock edges. That delay stands in for the part's access time, which is 70 ns nominal, or seven edges at 100 MHz.

The bidirectional data bus is split into three signals: a write-data input, a read-data output and a per-byte drive enable. An external pad ring or bus model combines the drive enable with the read data to produce the tri-state bus. A standby flag reports when the part would drop into its low-power state. Every output is registered, so all outputs reflect the pins sampled at the previous rising edge. The array itself has no reset, so its contents survive both standby and reset.

Top module: `lane_sram`

## Requirements
- R1: The part is selected only when `ceLoN` is 0 and `ceHi` is 1. When it is not selected, a write strobe changes no stored byte and both drive-enable bits are 0 after the edge.
- R2: At an edge where the part is selected and `wrN` is 0, the write-data bits 7:0 go into the addressed word if `loByteN` is 0, and bits 15:8 go in if `hiByteN` is 0. A byte whose enable is 1 keeps its previous value exactly.
- R3: A read is an edge with the part selected, `oeN` at 0 and `wrN` at 1. After LATENCY consecutive read edges with the same word index and the same byte enables, bit 0 of `laneDrive` is 1 and `rdData[7:0]` holds the stored low byte if `loByteN` is 0. Bit 1 of `laneDrive` and `rdData[15:8]` behave the same way for the high byte with `hiByteN`.
- R4: A lane whose drive bit is 0 presents 0 on its eight bits of `rdData`.
- R5: `laneDrive` is 00 after any edge at which the part is deselected, `oeN` is 1, both byte enables are 1, or a write is in progress.
- R6: A write takes priority over the output enable. With `wrN` at 0, no lane is driven, whatever the level of `oeN`.
- R7: `standby` is 1 after an edge exactly when the part was deselected or both byte enables were 1 at that edge. Otherwise it is 0.
- R8: Only the low log2(DEPTH) address bits select a word. Higher address bits are ignored and do not restart a read in progress.
- R9: While `rstN` is 0, `laneDrive` is 00, `rdData` is 0 and `standby` is 1. The stored words are not cleared by reset.
- R10: A change of word index, of either byte enable, or a break in the read restarts the LATENCY count, and no lane is driven until the count completes again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset of control and output registers |
| ceLoN | input | 1 | Chip enable, active low |
| ceHi | input | 1 | Chip enable, active high |
| wrN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| hiByteN | input | 1 | Enable for bits 15:8, active low |
| loByteN | input | 1 | Enable for bits 7:0, active low |
| addr | input | ADDR_W | Word address |
| wrData | input | 16 | Data to store |
| rdData | output | 16 | Read data, zero on undriven lanes |
| laneDrive | output | 2 | Per-byte bus drive enable; bit 0 covers bits 7:0 |
| standby | output | 1 | Low-power state flag |

## Verification
The bench builds the block with DEPTH 64, LATENCY 2 and the full 19-bit address port. The shallow array lets a reference copy cover every word, including a sweep that fills all 64 words and then overlays partial-byte writes. The 13 address bits above the index can be set to show that a read aliases and keeps counting. LATENCY 2 is the shortest setting where a first edge with no drive can be told apart from a second edge that drives. That difference exposes both the access delay and its restart.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // strobes from control to datapath, valid for the current edge
  typedef struct packed {
    logic [LANES-1:0] wrLane;   // store this byte lane
    logic [LANES-1:0] showLane; // present this byte lane
    logic             standby;  // low-power condition
  } ramStrobes_t;
endpackage

// File: rtl/lane_sram_ctl.sv
module lane_sram_ctl
  import lane_sram_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int LATENCY = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceLoN,
  input  logic             ceHi,
  input  logic             wrN,
  input  logic             oeN,
  input  logic             hiByteN,
  input  logic             loByteN,
  input  logic [IDX_W-1:0] idx,
  output ramStrobes_t      strb
);
  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LATENCY);
  localparam int KEY_W = IDX_W + 2;

  logic selected, doWrite, doRead, ready;
  logic [KEY_W-1:0] accessKey, lastKey;
  logic [CNT_W-1:0] runCnt, nextCnt;
  logic lastRead;

  assign selected  = !ceLoN && ceHi;
  assign doWrite   = selected && !wrN;
  assign doRead    = selected && wrN && !oeN;
  assign accessKey = {idx, hiByteN, loByteN};

  // count consecutive edges of an unchanged read, saturating at LATENCY
  always_comb begin
    if (!doRead)                                   nextCnt = '0;
    else if (lastRead && accessKey == lastKey)     nextCnt = (runCnt == LAT_C) ? runCnt : runCnt + 1'b1;
    else                                           nextCnt = CNT_W'(1);
  end

  assign ready = (nextCnt == LAT_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt   <= '0;
      lastKey  <= '0;
      lastRead <= 1'b0;
    end else begin
      runCnt   <= nextCnt;
      lastKey  <= accessKey;
      lastRead <= doRead;
    end
  end

  always_comb begin
    strb.wrLane   = {doWrite && !hiByteN, doWrite && !loByteN};
    strb.showLane = {doRead && ready && !hiByteN, doRead && ready && !loByteN};
    strb.standby  = !selected || (hiByteN && loByteN);
  end
endmodule

// File: rtl/lane_sram_dp.sv
module lane_sram_dp
  import lane_sram_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wrData,
  input  ramStrobes_t       strb,
  output logic [WORD_W-1:0] rdData,
  output logic [LANES-1:0]  laneDrive,
  output logic              standby
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] laneOut;
    logic              laneOn;

    // array has no reset: contents persist through reset and standby
    always_ff @(posedge clk) begin
      if (strb.wrLane[g]) bank[idx] <= wrData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneOut <= '0;
        laneOn  <= 1'b0;
      end else begin
        laneOn  <= strb.showLane[g];
        laneOut <= strb.showLane[g] ? bank[idx] : '0;
      end
    end

    assign rdData[g*LANE_W +: LANE_W] = laneOut;
    assign laneDrive[g]               = laneOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) standby <= 1'b1;
    else       standby <= strb.standby;
  end
endmodule

// File: rtl/lane_sram.sv
module lane_sram
  import lane_sram_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int ADDR_W  = 19,
  parameter int LATENCY = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceLoN,
  input  logic              ceHi,
  input  logic              wrN,
  input  logic              oeN,
  input  logic              hiByteN,
  input  logic              loByteN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic [1:0]        laneDrive,
  output logic              standby
);
  localparam int IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);

  logic [IDX_W-1:0] idx;
  ramStrobes_t      strb;

  assign idx = addr[IDX_W-1:0];

  if (ADDR_W > IDX_W) begin : gHighAddr
    logic unusedAddrBits;
    assign unusedAddrBits = ^addr[ADDR_W-1:IDX_W];
  end

  lane_sram_ctl #(.IDX_W(IDX_W), .LATENCY(LATENCY)) uCtl (
    .clk(clk), .rstN(rstN), .ceLoN(ceLoN), .ceHi(ceHi), .wrN(wrN), .oeN(oeN),
    .hiByteN(hiByteN), .loByteN(loByteN), .idx(idx), .strb(strb)
  );

  lane_sram_dp #(.DEPTH(DEPTH), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .idx(idx), .wrData(wrData), .strb(strb),
    .rdData(rdData), .laneDrive(laneDrive), .standby(standby)
  );
endmodule

// File: rtl/lane_sram_chk.sv
module lane_sram_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ceLoN,
  input logic        ceHi,
  input logic        wrN,
  input logic        oeN,
  input logic        hiByteN,
  input logic        loByteN,
  input logic [15:0] rdData,
  input logic [1:0]  laneDrive,
  input logic        standby
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ceLoN || !ceHi) |=> (laneDrive == 2'b00 && standby)); // R1
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (!ceLoN && ceHi && !wrN) |=> (laneDrive == 2'b00)); // R6
  AST_OE_OFF_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> (laneDrive == 2'b00)); // R5
  AST_BYTES_OFF_STANDBY: assert property (@(posedge clk) disable iff (!rstN)
    (hiByteN && loByteN) |=> (standby && laneDrive == 2'b00)); // R7
  AST_SELECTED_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    (!ceLoN && ceHi && !(hiByteN && loByteN)) |=> !standby); // R7
  AST_LO_LANE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    laneDrive[0] |-> !$past(loByteN)); // R3
  AST_HI_LANE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    laneDrive[1] |-> !$past(hiByteN)); // R3
  AST_IDLE_LO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !laneDrive[0] |-> (rdData[7:0] == 8'h00)); // R4
  AST_IDLE_HI_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !laneDrive[1] |-> (rdData[15:8] == 8'h00)); // R4
endmodule

bind lane_sram lane_sram_chk uChk (.*);

// File: tb/lane_sram_test.sv
module lane_sram_test;
  localparam int DEPTH = 64;
  localparam int ADDR_W = 19;
  localparam int LATENCY = 2;
  localparam int NROWS = 21;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceLoN = 1'b1, ceHi = 1'b0, wrN = 1'b1, oeN = 1'b1, hiByteN = 1'b1, loByteN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0] laneDrive;
  logic standby;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [15:0] refMem [DEPTH];

  always #5 clk = ~clk;

  lane_sram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LATENCY(LATENCY)) uut (
    .clk(clk), .rstN(rstN), .ceLoN(ceLoN), .ceHi(ceHi), .wrN(wrN), .oeN(oeN),
    .hiByteN(hiByteN), .loByteN(loByteN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .laneDrive(laneDrive), .standby(standby)
  );

  // row: ctl{ceLoN,ceHi,wrN,oeN,hiByteN,loByteN}, addr, wrData, exp laneDrive, exp rdData, exp standby
  localparam logic [59:0] VEC [NROWS] = '{
    {6'b010100, 19'd3,  16'hA1B2, 2'b00, 16'h0000, 1'b0}, // 0 write both lanes (R2)
    {6'b010110, 19'd4,  16'h1234, 2'b00, 16'h0000, 1'b0}, // 1 write low lane only (R2)
    {6'b010101, 19'd4,  16'h5678, 2'b00, 16'h0000, 1'b0}, // 2 write high lane only (R2)
    {6'b011000, 19'd3,  16'h0000, 2'b00, 16'h0000, 1'b0}, // 3 read, first edge (R3)
    {6'b011000, 19'd3,  16'h0000, 2'b11, 16'hA1B2, 1'b0}, // 4 read valid (R3)
    {6'b011000, 19'd67, 16'h0000, 2'b11, 16'hA1B2, 1'b0}, // 5 alias above depth (R8)
    {6'b011010, 19'd4,  16'h0000, 2'b00, 16'h0000, 1'b0}, // 6 restart (R10)
    {6'b011010, 19'd4,  16'h0000, 2'b01, 16'h0034, 1'b0}, // 7 low lane only (R4)
    {6'b011001, 19'd4,  16'h0000, 2'b00, 16'h0000, 1'b0}, // 8 enables change restart (R10)
    {6'b011001, 19'd4,  16'h0000, 2'b10, 16'h5600, 1'b0}, // 9 high lane only (R4)
    {6'b011100, 19'd4,  16'h0000, 2'b00, 16'h0000, 1'b0}, // 10 output enable off (R5)
    {6'b111000, 19'd4,  16'h0000, 2'b00, 16'h0000, 1'b1}, // 11 active-low enable high (R1)
    {6'b001000, 19'd4,  16'h0000, 2'b00, 16'h0000, 1'b1}, // 12 active-high enable low (R1)
    {6'b011011, 19'd4,  16'h0000, 2'b00, 16'h0000, 1'b1}, // 13 both bytes off (R7)
    {6'b010000, 19'd3,  16'h0F0F, 2'b00, 16'h0000, 1'b0}, // 14 write with oe low (R6)
    {6'b110000, 19'd4,  16'hDEAD, 2'b00, 16'h0000, 1'b1}, // 15 deselected write (R1)
    {6'b010011, 19'd4,  16'hBEEF, 2'b00, 16'h0000, 1'b1}, // 16 write no bytes (R2)
    {6'b011000, 19'd4,  16'h0000, 2'b00, 16'h0000, 1'b0}, // 17
    {6'b011000, 19'd4,  16'h0000, 2'b11, 16'h5634, 1'b0}, // 18 merged word intact (R2)
    {6'b011000, 19'd3,  16'h0000, 2'b00, 16'h0000, 1'b0}, // 19
    {6'b011000, 19'd3,  16'h0000, 2'b11, 16'h0F0F, 1'b0}  // 20 write landed (R6)
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] ctl, input logic [ADDR_W-1:0] a, input logic [15:0] d);
    {ceLoN, ceHi, wrN, oeN, hiByteN, loByteN} = ctl;
    addr = a;
    wrData = d;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset laneDrive", {14'd0, laneDrive}, 16'h0000);
    check("R9 reset rdData", rdData, 16'h0000);
    check("R9 reset standby", {15'd0, standby}, 16'h0001);
    rstN = 1'b1;

    @(negedge clk);
    apply(VEC[0][59:54], VEC[0][53:35], VEC[0][34:19]);
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      check($sformatf("R5 row %0d laneDrive", i), {14'd0, laneDrive}, {14'd0, VEC[i][18:17]});
      check($sformatf("R3 row %0d rdData", i), rdData, VEC[i][16:1]);
      check($sformatf("R7 row %0d standby", i), {15'd0, standby}, {15'd0, VEC[i][0]});
      if (i < NROWS - 1) apply(VEC[i+1][59:54], VEC[i+1][53:35], VEC[i+1][34:19]);
    end

    // R9: reset mid-run keeps the array
    apply(6'b111111, '0, '0);
    @(negedge clk);
    apply(6'b011000, 19'd3, '0);
    rstN = 1'b0;
    #1;
    check("R9 mid reset laneDrive", {14'd0, laneDrive}, 16'h0000);
    check("R9 mid reset standby", {15'd0, standby}, 16'h0001);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 first read edge not driven", {14'd0, laneDrive}, 16'h0000);
    @(negedge clk);
    check("R9 contents survive reset", rdData, 16'h0F0F);

    // R2: reference array, full fill then partial overlays
    for (int a = 0; a < DEPTH; a++) begin
      refMem[a] = 16'(a * 16'h0101) ^ 16'h5A3C;
      apply(6'b010100, ADDR_W'(a), refMem[a]);
      @(negedge clk);
    end
    for (int k = 0; k < 40; k++) begin
      int a;
      logic [1:0] lanes;
      logic [15:0] d;
      a = (k * 7 + 1) % DEPTH;
      lanes = 2'(k % 4);
      d = 16'(k * 16'h1357 + 16'h2468);
      if (lanes[0]) refMem[a][7:0] = d[7:0];
      if (lanes[1]) refMem[a][15:8] = d[15:8];
      apply({4'b0101, !lanes[1], !lanes[0]}, ADDR_W'(a), d);
      @(negedge clk);
    end
    for (int a = 0; a < DEPTH; a++) begin
      apply(6'b011000, ADDR_W'(a), '0);
      @(negedge clk);
      @(negedge clk);
      check($sformatf("R2 word %0d", a), rdData, refMem[a]);
    end

    apply(6'b111111, '0, '0);
    @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule